// File: doc/BRIEF.md
# String Block Transfer Engine

This engine carries out repeated string-style data transfers of bytes, words or doublewords. A caller gives it a source segment and offset, a destination segment and offset, an element size, a direction flag, a repeat count, a fixed I/O port address and an accumulator value, then pulses `start`. The engine walks the elements one byte per clock over a byte-wide memory port, or a byte-wide I/O port, and steps its two index registers and its count as it goes. It pulses `done` when the count reaches zero. The final indices, the remaining count and the accumulator stay visible on outputs.

Five transfer modes are supported. A move copies source memory to destination memory. A load fills the accumulator from source memory. A store writes the accumulator to destination memory. An input mode copies from the I/O port to destination memory, and an output mode copies from source memory to the I/O port. The memory port reads combinationally: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_re` is high.

Top module: `strx_engine`

## Requirements
- R1: With `dir`=0 each index that a mode uses grows by the element size after every element. With `dir`=1 it shrinks by that amount. Offsets wrap modulo 2^16.
- R2: `size` code 0 is a byte (step 1), code 1 is a word (step 2), and codes 2 and 3 are a doubleword (step 4).
- R3: `mode` code 0 (move) reads each element from the source address and writes it to the destination address. Both indices step.
- R4: `mode` code 1 (load) reads each element from the source address into the low bytes of `acc_out`. The remaining accumulator bytes keep their `acc_in` value. Only the source index steps, and there are no writes.
- R5: `mode` code 2 (store) writes the low bytes of `acc_in` to the destination address for every element. Only the destination index steps, and there are no reads.
- R6: `mode` code 3 (input) reads byte k of each element from I/O address `port_addr`+k and writes it to the destination. Only the destination index steps.
- R7: `mode` code 4 (output) reads each element from the source and writes byte k of it to I/O address `port_addr`+k. Only the source index steps.
- R8: A start with `count`=0, or with a `mode` code of 5 to 7, transfers nothing. It raises `done` on the clock after the one that took `start`, and it leaves the indices unchanged.
- R9: `count_left` drops by one per finished element. The operation ends when it reaches zero, with a `done` pulse exactly one cycle long.
- R10: The physical address is segment×16 plus offset, on 20 bits. Byte k of an element sits at the element address plus k (little-endian), and one byte moves per clock. An operation therefore takes count×n cycles for load or store, and count×2n cycles for the other modes, where n is the element size in bytes. `done` is seen one cycle after that many cycles following the start edge.
- R11: `start` is ignored while `busy` is high. A pulse during an operation neither alters it nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 3 | Transfer mode code |
| size | input | 2 | Element size code |
| dir | input | 1 | 0 increment, 1 decrement |
| src_seg | input | 16 | Source segment |
| src_off | input | 16 | Source starting offset |
| dst_seg | input | 16 | Destination segment |
| dst_off | input | 16 | Destination starting offset |
| count | input | 16 | Number of elements |
| port_addr | input | 16 | I/O port base address |
| acc_in | input | 32 | Accumulator value at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_idx | output | 16 | Current source offset |
| dst_idx | output | 16 | Current destination offset |
| count_left | output | 16 | Remaining element count |
| acc_out | output | 32 | Accumulator contents |
| mem_addr | output | 20 | Memory byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte (combinational) |
| io_addr | output | 16 | I/O byte address |
| io_re | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 8 | I/O read byte (combinational) |

## Verification
The bench targets decrementing transfers of multi-byte elements. A design that moved the index before the element, or stored the bytes big-endian, would place data one element off or byte-reversed in the destination. It checks that load and store touch only the one index and the one memory direction they own; a design sharing the update logic would drift the unused index or issue stray reads. It checks that a zero count and an undefined mode finish at once without touching memory, where a naive design would run 65536 elements. It also checks that a start pulse during a busy operation is dropped, and that a segment above 0x00FF yields a full 20-bit address, so a design that truncated the shifted segment would write to the wrong place.

// File: rtl/strx_pkg.sv
package strx_pkg;

    localparam int ACC_W = 32;

    typedef enum logic [2:0] {
        MD_MOVE  = 3'd0,
        MD_LOAD  = 3'd1,
        MD_STORE = 3'd2,
        MD_IN    = 3'd3,
        MD_OUT   = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    // bytes per element for a size code
    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // index of the final byte lane of an element
    function automatic logic [1:0] last_lane(input logic [1:0] sz);
        case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/strx_agen.sv
module strx_agen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = SEG_W + 4
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       lane,
    output logic [PA_W-1:0]  pa
);
    // segment shifted by four plus offset plus byte lane
    always_comb begin
        pa = PA_W'({seg, 4'b0000}) + PA_W'(off) + PA_W'(lane);
    end
endmodule

// File: rtl/strx_step.sv
module strx_step
    import strx_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic             dir,
    output logic [OFF_W-1:0] nxt
);
    logic [OFF_W-1:0] amt;

    always_comb begin
        amt = OFF_W'(elem_bytes(size));
        nxt = dir ? (off - amt) : (off + amt);
    end
endmodule

// File: rtl/strx_engine.sv
module strx_engine
    import strx_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [1:0]        size,
    input  logic              dir,
    input  logic [SEG_W-1:0]  src_seg,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [SEG_W-1:0]  dst_seg,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic [CNT_W-1:0]  count,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [ACC_W-1:0]  acc_in,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  src_idx,
    output logic [OFF_W-1:0]  dst_idx,
    output logic [CNT_W-1:0]  count_left,
    output logic [ACC_W-1:0]  acc_out,
    output logic [SEG_W+3:0]  mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [PORT_W-1:0] io_addr,
    output logic              io_re,
    output logic              io_we,
    output logic [7:0]        io_wdata,
    input  logic [7:0]        io_rdata
);
    localparam int PA_W  = SEG_W + 4;
    localparam int NCH   = 2;   // channel 0 source, channel 1 destination

    typedef struct packed {
        state_e             st;
        mode_e              mode;
        logic [1:0]         size;
        logic               dir;
        logic [SEG_W-1:0]   src_seg;
        logic [OFF_W-1:0]   src_off;
        logic [SEG_W-1:0]   dst_seg;
        logic [OFF_W-1:0]   dst_off;
        logic [PORT_W-1:0]  port;
        logic [CNT_W-1:0]   cnt;
        logic [ACC_W-1:0]   acc;
        logic [ACC_W-1:0]   xbuf;
        logic [1:0]         lane;
        logic               done;
    } regs_t;

    regs_t q, n;

    // per-channel address and next-index generation
    logic [SEG_W-1:0] ch_seg  [NCH];
    logic [OFF_W-1:0] ch_off  [NCH];
    logic [PA_W-1:0]  ch_pa   [NCH];
    logic [OFF_W-1:0] ch_next [NCH];

    assign ch_seg[0] = q.src_seg;
    assign ch_off[0] = q.src_off;
    assign ch_seg[1] = q.dst_seg;
    assign ch_off[1] = q.dst_off;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        strx_agen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_agen (
            .seg  (ch_seg[g]),
            .off  (ch_off[g]),
            .lane (q.lane),
            .pa   (ch_pa[g])
        );
        strx_step #(.OFF_W(OFF_W)) u_step (
            .off  (ch_off[g]),
            .size (q.size),
            .dir  (q.dir),
            .nxt  (ch_next[g])
        );
    end

    logic [7:0] rd_byte;
    logic       elem_end;
    logic       lane_last;
    logic       mode_ok;

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        io_addr   = '0;
        io_re     = 1'b0;
        io_we     = 1'b0;
        io_wdata  = '0;
        rd_byte   = '0;
        elem_end  = 1'b0;
        lane_last = (q.lane == last_lane(q.size));
        mode_ok   = (mode <= 3'd4);

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (mode_ok && (count != '0)) begin
                        n.mode    = mode_e'(mode);
                        n.size    = size;
                        n.dir     = dir;
                        n.src_seg = src_seg;
                        n.src_off = src_off;
                        n.dst_seg = dst_seg;
                        n.dst_off = dst_off;
                        n.port    = port_addr;
                        n.cnt     = count;
                        n.acc     = acc_in;
                        n.lane    = '0;
                        n.st      = (mode == 3'(MD_STORE)) ? ST_WRITE : ST_READ;
                    end else begin
                        n.done = 1'b1;
                    end
                end
            end

            ST_READ: begin
                if (q.mode == MD_IN) begin
                    io_re   = 1'b1;
                    io_addr = q.port + PORT_W'(q.lane);
                    rd_byte = io_rdata;
                end else begin
                    mem_re   = 1'b1;
                    mem_addr = ch_pa[0];
                    rd_byte  = mem_rdata;
                end
                n.xbuf[{q.lane, 3'b000} +: 8] = rd_byte;
                if (q.mode == MD_LOAD) begin
                    n.acc[{q.lane, 3'b000} +: 8] = rd_byte;
                end
                if (lane_last) begin
                    n.lane = '0;
                    if (q.mode == MD_LOAD) begin
                        elem_end = 1'b1;
                    end else begin
                        n.st = ST_WRITE;
                    end
                end else begin
                    n.lane = q.lane + 2'd1;
                end
            end

            ST_WRITE: begin
                if (q.mode == MD_OUT) begin
                    io_we    = 1'b1;
                    io_addr  = q.port + PORT_W'(q.lane);
                    io_wdata = q.xbuf[{q.lane, 3'b000} +: 8];
                end else begin
                    mem_we    = 1'b1;
                    mem_addr  = ch_pa[1];
                    mem_wdata = (q.mode == MD_STORE) ? q.acc[{q.lane, 3'b000} +: 8]
                                                     : q.xbuf[{q.lane, 3'b000} +: 8];
                end
                if (lane_last) begin
                    elem_end = 1'b1;
                    n.lane   = '0;
                end else begin
                    n.lane = q.lane + 2'd1;
                end
            end

            default: n.st = ST_IDLE;
        endcase

        if (elem_end) begin
            if (q.mode inside {MD_MOVE, MD_LOAD, MD_OUT}) n.src_off = ch_next[0];
            if (q.mode inside {MD_MOVE, MD_STORE, MD_IN}) n.dst_off = ch_next[1];
            n.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                n.st   = ST_IDLE;
                n.done = 1'b1;
            end else begin
                n.st = (q.mode == MD_STORE) ? ST_WRITE : ST_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign src_idx    = q.src_off;
    assign dst_idx    = q.dst_off;
    assign count_left = q.cnt;
    assign acc_out    = q.acc;

    // R10: never a read and a write in the same cycle on either port
    a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we) && !(io_re && io_we) && !((mem_re || mem_we) && (io_re || io_we)));

    // R4: load mode never writes anywhere
    a_r4_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.mode == MD_LOAD) |-> (!mem_we && !io_we));

    // R5: store mode never reads anything
    a_r5_store_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.mode == MD_STORE) |-> (!mem_re && !io_re));

    // R6: input mode reads only from the I/O side
    a_r6_in_reads_io: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.mode == MD_IN) |-> (!mem_re && !io_we));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: count only holds or drops by one while running
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((q.cnt == $past(q.cnt)) || (q.cnt == $past(q.cnt) - CNT_W'(1))));

    // R1: source index holds or moves by one element in the flagged direction
    a_r1_src_dir: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((q.src_off == $past(q.src_off)) ||
                  (!q.dir && q.src_off == $past(q.src_off) + OFF_W'(elem_bytes(q.size))) ||
                  ( q.dir && q.src_off == $past(q.src_off) - OFF_W'(elem_bytes(q.size)))));

    // R8: zero count started from idle completes on the next cycle
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && count == '0) |=> (done && !busy));

    // R11: operation parameters hold while running
    a_r11_hold_params: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.mode) && $stable(q.size) && $stable(q.dir)));

endmodule

// File: tb/strx_engine_tb.sv
`timescale 1ns/1ps
module strx_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic        dir = 1'b0;
    logic [15:0] src_seg = '0, src_off = '0, dst_seg = '0, dst_off = '0;
    logic [15:0] count = '0;
    logic [15:0] port_addr = 16'h03AC;
    logic [31:0] acc_in = '0;
    logic        busy, done;
    logic [15:0] src_idx, dst_idx, count_left;
    logic [31:0] acc_out;
    logic [19:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] io_addr;
    logic        io_re, io_we;
    logic [7:0]  io_wdata, io_rdata;

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] iopat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    logic [7:0]  mem [4096];
    logic        fill_req = 1'b0;
    int          nwr = 0, nrd = 0, stray = 0, ocnt = 0;
    logic [7:0]  olog [64];
    logic [15:0] oaddr [64];
    logic [19:0] last_wa = '0;
    logic [7:0]  last_wd = '0;

    assign mem_rdata = mem[mem_addr[11:0]];
    assign io_rdata  = iopat(io_addr);

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 4096; i++) mem[i] <= pat(12'(i));
        end else if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
        end
        if (mem_we) begin
            nwr     <= nwr + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
            if (mem_addr[19:12] != 8'h00) stray <= stray + 1;
        end
        if (mem_re) nrd <= nrd + 1;
        if (io_we) begin
            olog[ocnt % 64]  <= io_wdata;
            oaddr[ocnt % 64] <= io_addr;
            ocnt <= ocnt + 1;
        end
    end

    strx_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size), .dir(dir),
        .src_seg(src_seg), .src_off(src_off), .dst_seg(dst_seg), .dst_off(dst_off),
        .count(count), .port_addr(port_addr), .acc_in(acc_in),
        .busy(busy), .done(done), .src_idx(src_idx), .dst_idx(dst_idx),
        .count_left(count_left), .acc_out(acc_out),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_addr(io_addr), .io_re(io_re), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        @(negedge clk);
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] md, input logic [1:0] sz, input logic dr,
                          input logic [15:0] ss, input logic [15:0] so,
                          input logic [15:0] ds, input logic [15:0] dof,
                          input logic [15:0] cn, input logic [31:0] ac,
                          output int cyc);
        @(negedge clk);
        mode = md; size = sz; dir = dr;
        src_seg = ss; src_off = so; dst_seg = ds; dst_off = dof;
        count = cn; acc_in = ac; start = 1'b1;
        cyc = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 5000);
        if (cyc >= 5000) chk("R9 operation never finished", 32'(cyc), 32'd0);
    endtask

    // stimulus: mode, size, dir, src_off, dst_off, count | expected src_idx, dst_idx
    localparam int NV = 9;
    localparam logic [101:0] VEC [NV] = '{
        {3'd0, 2'd0, 1'b0, 16'h0000, 16'h0000, 16'd12, 16'h000C, 16'h000C},
        {3'd0, 2'd1, 1'b1, 16'h0020, 16'h0030, 16'd3,  16'h001A, 16'h002A},
        {3'd0, 2'd2, 1'b0, 16'h0040, 16'h0050, 16'd2,  16'h0048, 16'h0058},
        {3'd1, 2'd1, 1'b0, 16'h0060, 16'h0070, 16'd2,  16'h0064, 16'h0070},
        {3'd2, 2'd2, 1'b1, 16'h0080, 16'h0090, 16'd2,  16'h0080, 16'h0088},
        {3'd3, 2'd0, 1'b0, 16'h00B0, 16'h00A0, 16'd4,  16'h00B0, 16'h00A4},
        {3'd4, 2'd1, 1'b0, 16'h00C0, 16'h00D0, 16'd2,  16'h00C4, 16'h00D0},
        {3'd1, 2'd2, 1'b1, 16'h00E0, 16'h00F0, 16'd1,  16'h00DC, 16'h00F0},
        {3'd0, 2'd0, 1'b1, 16'h0005, 16'h0105, 16'd3,  16'h0002, 16'h0102}
    };

    localparam logic [15:0] SSEG = 16'h0010;
    localparam logic [15:0] DSEG = 16'h0040;
    localparam logic [31:0] ACC0 = 32'hA1B2C3D4;

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int cyc;
        int rd0, wr0, oc0, st0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset busy", 32'(busy), 32'd0);
        chk("R9 reset done", 32'(done), 32'd0);
        chk("R9 reset count_left", 32'(count_left), 32'd0);
        chk("R1 reset src_idx", 32'(src_idx), 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  md;
            logic [1:0]  sz;
            logic        dr;
            logic [15:0] so, dof, cn, es, ed;
            int          nb, per, bad;
            logic [31:0] exp_acc;
            {md, sz, dr, so, dof, cn, es, ed} = VEC[v];
            nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            per = (md == 3'd1 || md == 3'd2) ? nb : 2 * nb;
            fill_mem();
            rd0 = nrd; wr0 = nwr; oc0 = ocnt; st0 = stray;
            run_op(md, sz, dr, SSEG, so, DSEG, dof, cn, ACC0, cyc);
            chk($sformatf("R1 R2 vec%0d src_idx", v), 32'(src_idx), 32'(es));
            chk($sformatf("R1 R2 vec%0d dst_idx", v), 32'(dst_idx), 32'(ed));
            chk($sformatf("R9 vec%0d count_left", v), 32'(count_left), 32'd0);
            chk($sformatf("R10 vec%0d cycles", v), 32'(cyc), 32'(1 + cn * per));
            chk($sformatf("R4 R5 vec%0d reads", v), 32'(nrd - rd0),
                (md == 3'd0 || md == 3'd1 || md == 3'd4) ? 32'(cn * nb) : 32'd0);
            chk($sformatf("R4 R5 vec%0d writes", v), 32'(nwr - wr0),
                (md == 3'd0 || md == 3'd2 || md == 3'd3) ? 32'(cn * nb) : 32'd0);
            chk($sformatf("R10 vec%0d address range", v), 32'(stray - st0), 32'd0);

            bad = 0;
            exp_acc = ACC0;
            for (int e = 0; e < int'(cn); e++) begin
                logic [15:0] so_e, do_e;
                so_e = dr ? so - 16'(e * nb) : so + 16'(e * nb);
                do_e = dr ? dof - 16'(e * nb) : dof + 16'(e * nb);
                for (int k = 0; k < nb; k++) begin
                    logic [11:0] sa, da;
                    logic [7:0]  ev;
                    sa = 12'h100 + so_e[11:0] + 12'(k);
                    da = 12'h400 + do_e[11:0] + 12'(k);
                    case (md)
                        3'd0: ev = pat(sa);
                        3'd2: ev = ACC0[8*k +: 8];
                        3'd3: ev = iopat(port_addr + 16'(k));
                        default: ev = pat(sa);
                    endcase
                    if (md == 3'd0 || md == 3'd2 || md == 3'd3) begin
                        if (mem[da] !== ev) begin
                            if (bad == 0) chk($sformatf("R3 R5 R6 R10 vec%0d data e%0d b%0d", v, e, k),
                                              32'(mem[da]), 32'(ev));
                            bad++;
                        end
                    end else if (md == 3'd4) begin
                        int li;
                        li = (oc0 + e * nb + k) % 64;
                        if (olog[li] !== ev || oaddr[li] !== port_addr + 16'(k)) begin
                            if (bad == 0) chk($sformatf("R7 vec%0d port e%0d b%0d", v, e, k),
                                              {oaddr[li], 8'h00, olog[li]},
                                              {port_addr + 16'(k), 8'h00, ev});
                            bad++;
                        end
                    end else if (e == int'(cn) - 1) begin
                        exp_acc[8*k +: 8] = ev;
                    end
                end
            end
            if (bad == 0) chk($sformatf("R3 R6 R7 vec%0d data", v), 32'd0, 32'd0);
            if (md == 3'd1) chk($sformatf("R4 vec%0d acc_out", v), acc_out, exp_acc);
            @(negedge clk);
            chk($sformatf("R9 vec%0d done pulse length", v), 32'(done), 32'd0);
        end

        // R8: zero count completes at once with indices unchanged
        wr0 = nwr; rd0 = nrd;
        run_op(3'd0, 2'd1, 1'b0, SSEG, 16'h0300, DSEG, 16'h0310, 16'd0, ACC0, cyc);
        chk("R8 zero count cycles", 32'(cyc), 32'd1);
        chk("R8 zero count no access", 32'((nwr - wr0) + (nrd - rd0)), 32'd0);
        chk("R8 zero count src_idx unchanged", 32'(src_idx), 32'h0002);
        chk("R8 zero count dst_idx unchanged", 32'(dst_idx), 32'h0102);

        // R8: undefined mode code 6 behaves the same
        wr0 = nwr; rd0 = nrd;
        run_op(3'd6, 2'd0, 1'b0, SSEG, 16'h0300, DSEG, 16'h0310, 16'd5, ACC0, cyc);
        chk("R8 bad mode cycles", 32'(cyc), 32'd1);
        chk("R8 bad mode no access", 32'((nwr - wr0) + (nrd - rd0)), 32'd0);
        chk("R8 bad mode count_left unchanged", 32'(count_left), 32'd0);

        // R10: full 20-bit physical address with a high segment
        run_op(3'd2, 2'd0, 1'b0, 16'h0000, 16'h0000, 16'h1234, 16'h0010, 16'd1, 32'h000000AB, cyc);
        chk("R10 physical write address", 32'(last_wa), 32'h12350);
        chk("R10 physical write data", 32'(last_wd), 32'hAB);
        chk("R10 dst index after one byte", 32'(dst_idx), 32'h0011);

        // R11: start pulse during a busy operation is dropped
        begin
            int c;
            fill_mem();
            wr0 = nwr;
            @(negedge clk);
            mode = 3'd0; size = 2'd0; dir = 1'b0;
            src_seg = SSEG; src_off = 16'h0010; dst_seg = DSEG; dst_off = 16'h0010;
            count = 16'd2; acc_in = ACC0; start = 1'b1;
            @(negedge clk);
            mode = 3'd2; dst_off = 16'h0200; count = 16'd9; start = 1'b1;
            c = 1;
            @(negedge clk);
            start = 1'b0;
            c++;
            while (!done && c < 100) begin
                @(negedge clk);
                c++;
            end
            chk("R11 first op cycles", 32'(c), 32'd5);
            chk("R11 dst_idx of first op", 32'(dst_idx), 32'h0012);
            chk("R11 count_left", 32'(count_left), 32'd0);
            repeat (3) @(negedge clk);
            chk("R11 no queued op", 32'(busy), 32'd0);
            chk("R11 writes of first op only", 32'(nwr - wr0), 32'd2);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule